// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a fast input clock into the time base of a CAN bit. A prescaler divides the input clock into time quanta. A sequencer then walks each bit through three parts: a one-quantum sync segment, a first phase segment and a second phase segment. It flags the start of every bit and the sample point. A sampler latches the received bus level there, either as a single sample or as a two-out-of-three vote over the last three quanta.

Two configuration bytes set the timing. The block copies them only while the reset-mode input is high. While reset mode is active, all counters are held at their start state. Once reset mode is released, bits are timed from a fresh sync segment.

The block follows a transmitting node's clock drift by watching recessive-to-dominant edges on the receive line. An edge in the first phase segment lengthens it, and an edge in the second phase segment shortens it. Each correction is capped by the synchronization jump width, and only one correction is made per bit. When the hard-sync request is high, an edge instead restarts the bit at its sync segment.

Top module: `can_bit_timing`

## Requirements
- R1: `tq_tick` pulses for one clock every 2 × (P + 1) clocks, where P is `bt_byte0[5:0]`.
- R2: With no edges on `rx`, a bit lasts A + B + 3 quanta, where A is `bt_byte1[3:0]` and B is `bt_byte1[6:4]`.
- R3: `sample_strobe` pulses on a quantum tick, A + 1 ticks after the tick that carries `bit_start`.
- R4: `bit_start` pulses on the quantum tick that closes the single sync quantum.
- R5: A falling `rx` edge first seen on the tick that closes the k-th quantum of the first phase segment makes that segment longer by min(k, J + 1) quanta, where J is `bt_byte0[7:6]`.
- R6: A falling `rx` edge seen on a tick in the second phase segment, with r quanta of it still to come, makes that segment shorter by min(r, J + 1) quanta.
- R7: A falling edge seen on the sync quantum's tick changes nothing. Only the first correcting edge in a bit has an effect.
- R8: While `hard_sync_req` is high, a falling edge seen on a tick in either phase segment makes the next quantum a sync quantum, which starts a new bit.
- R9: `rx_bit` changes only in the clock after `sample_strobe`. It takes the value of `rx` on the sample tick when `bt_byte1[7]` is 0. When `bt_byte1[7]` is 1, it takes the majority of `rx` on the sample tick and the two ticks before it.
- R10: The configuration bytes are captured only while `reset_mode` is high. Changes to them at other times have no effect on timing.
- R11: While `reset_mode` is high, no tick or strobe is produced. The first tick after it falls carries `bit_start`.
- R12: After a synchronous reset (`rst_n` low), `rx_bit` is 1 and both captured bytes are zero, which gives a 3-quantum bit of 6 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bt_byte0 | input | 8 | Jump width [7:6], prescaler [5:0] |
| bt_byte1 | input | 8 | Triple-sample select [7], phase 2 field [6:4], phase 1 field [3:0] |
| reset_mode | input | 1 | Configuration window; holds the counters cleared |
| hard_sync_req | input | 1 | Bus idle; the next falling edge restarts the bit |
| rx | input | 1 | Synchronized receive line, 1 = recessive |
| tq_tick | output | 1 | One-clock pulse per time quantum |
| sample_strobe | output | 1 | One-clock pulse at the sample point |
| rx_bit | output | 1 | Sampled bit value |
| bit_start | output | 1 | One-clock pulse at the start of a bit |

## Verification
The assertions check the following on every cycle:
- ticks are never back to back;
- the configuration stays frozen outside reset mode;
- the sync segment lasts exactly one quantum;
- the segment counters stay within the longest allowed segment;
- strobes line up with ticks;
- the sampled bit changes only after a strobe.

Only the bench scenarios can show that bit lengths, sample offsets and corrected bit lengths match the field arithmetic. These scenarios also cover the jump-width cap in both phase segments, the one-correction-per-bit rule, hard synchronization and the majority vote against a one-quantum glitch.

// File: rtl/can_bt_pkg.sv
// Shared constants and types for the CAN bit timing generator.
// Assumes the fixed two-byte configuration layout described in the brief.
package can_bt_pkg;
    localparam int BRP_W  = 6;
    localparam int SJW_W  = 2;
    localparam int TS1_W  = 4;
    localparam int TS2_W  = 3;
    localparam int PRE_W  = BRP_W + 1;
    // Longest first phase segment plus the largest extension.
    localparam int QCNT_W = $clog2((1 << TS1_W) + (1 << SJW_W) + 1);

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;

    typedef struct packed {
        logic [SJW_W-1:0] sjw;
        logic [BRP_W-1:0] brp;
        logic             sam;
        logic [TS2_W-1:0] tseg2;
        logic [TS1_W-1:0] tseg1;
    } timing_t;
endpackage

// File: rtl/can_bt_cfg.sv
// Configuration capture: copies the two timing bytes while reset mode is
// high and holds them otherwise. Assumes the inputs are stable near clk.
module can_bt_cfg
    import can_bt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reset_mode,
    input  logic [7:0] byte0,
    input  logic [7:0] byte1,
    output timing_t    timing
);
    logic [7:0] b0_q, b1_q;

    // Load the bytes only inside the configuration window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b0_q <= '0;
            b1_q <= '0;
        end else if (reset_mode) begin
            b0_q <= byte0;
            b1_q <= byte1;
        end
    end

    // Split the bytes into named fields.
    always_comb begin
        timing.sjw   = b0_q[7:6];
        timing.brp   = b0_q[5:0];
        timing.sam   = b1_q[7];
        timing.tseg2 = b1_q[6:4];
        timing.tseg1 = b1_q[3:0];
    end

    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_mode |=> ($stable(b0_q) && $stable(b1_q)));
endmodule

// File: rtl/can_bt_prescaler.sv
// Quantum prescaler: emits a one-clock tick every 2*(brp+1) clocks.
// Assumes brp changes only while reset mode is high.
module can_bt_prescaler
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_mode,
    input  logic [BRP_W-1:0] brp,
    output logic             tq_tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] lim;

    assign lim     = {brp, 1'b1};
    assign tq_tick = !reset_mode && (cnt_q == lim);

    // Count clocks within a quantum; hold cleared in reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n || reset_mode) cnt_q <= '0;
        else if (tq_tick)         cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        tq_tick |=> !tq_tick);
    a_r11_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
        reset_mode |=> (cnt_q == '0));
endmodule

// File: rtl/can_bt_seq.sv
// Segment sequencer: walks sync, phase 1 and phase 2 on quantum ticks.
// It applies one jump-width-limited correction per bit and hard sync on
// request. Assumes rx is already synchronized to clk.
module can_bt_seq
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_mode,
    input  logic             tq_tick,
    input  logic             rx,
    input  logic             hard_sync_req,
    input  logic [SJW_W-1:0] sjw,
    input  logic [TS1_W-1:0] tseg1,
    input  logic [TS2_W-1:0] tseg2,
    output logic             sample_pt,
    output logic             bit_start
);
    localparam logic [QCNT_W-1:0] ONE = QCNT_W'(1);

    seg_e              seg_q, seg_d;
    logic [QCNT_W-1:0] qcnt_q, qcnt_d, adj_q, adj_d, shr_q, shr_d;
    logic              rs_q, rs_d, rx_prev_q;
    logic              fall, rs_go, hs_go;
    logic [QCNT_W-1:0] jw, len1, len2, err1, rem2, ext_n, shr_n, len1_now, len2_now;

    assign fall     = tq_tick && rx_prev_q && !rx;
    assign hs_go    = fall && hard_sync_req && (seg_q != SEG_SYNC);
    assign rs_go    = fall && !hard_sync_req && !rs_q;
    assign jw       = QCNT_W'(sjw) + ONE;
    assign len1     = QCNT_W'(tseg1) + ONE + adj_q;
    assign len2     = QCNT_W'(tseg2) + ONE - shr_q;
    assign err1     = qcnt_q + ONE;
    assign rem2     = len2 - qcnt_q - ONE;
    assign ext_n    = (err1 > jw) ? jw : err1;
    assign shr_n    = (rem2 > jw) ? jw : rem2;
    assign len1_now = rs_go ? len1 + ext_n : len1;
    assign len2_now = rs_go ? len2 - shr_n : len2;

    // Next-state logic for the segment walk and edge corrections.
    always_comb begin
        seg_d     = seg_q;
        qcnt_d    = qcnt_q;
        adj_d     = adj_q;
        shr_d     = shr_q;
        rs_d      = rs_q;
        sample_pt = 1'b0;
        bit_start = 1'b0;
        if (tq_tick) begin
            case (seg_q)
                SEG_SYNC: begin
                    bit_start = 1'b1;
                    seg_d     = SEG_PH1;
                    qcnt_d    = '0;
                    adj_d     = '0;
                    shr_d     = '0;
                    rs_d      = 1'b0;
                end
                SEG_PH1: begin
                    if (hs_go) begin
                        seg_d  = SEG_SYNC;
                        qcnt_d = '0;
                    end else begin
                        if (rs_go) begin
                            adj_d = adj_q + ext_n;
                            rs_d  = 1'b1;
                        end
                        if (qcnt_q == len1_now - ONE) begin
                            sample_pt = 1'b1;
                            seg_d     = SEG_PH2;
                            qcnt_d    = '0;
                        end else begin
                            qcnt_d = qcnt_q + ONE;
                        end
                    end
                end
                SEG_PH2: begin
                    if (hs_go) begin
                        seg_d  = SEG_SYNC;
                        qcnt_d = '0;
                    end else begin
                        if (rs_go) begin
                            shr_d = shr_q + shr_n;
                            rs_d  = 1'b1;
                        end
                        if (qcnt_q == len2_now - ONE) begin
                            seg_d  = SEG_SYNC;
                            qcnt_d = '0;
                        end else begin
                            qcnt_d = qcnt_q + ONE;
                        end
                    end
                end
                default: begin
                    seg_d  = SEG_SYNC;
                    qcnt_d = '0;
                end
            endcase
        end
    end

    // Segment state registers; restart at sync while in reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n || reset_mode) begin
            seg_q  <= SEG_SYNC;
            qcnt_q <= '0;
            adj_q  <= '0;
            shr_q  <= '0;
            rs_q   <= 1'b0;
        end else begin
            seg_q  <= seg_d;
            qcnt_q <= qcnt_d;
            adj_q  <= adj_d;
            shr_q  <= shr_d;
            rs_q   <= rs_d;
        end
    end

    // Bus level at the previous quantum tick, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || reset_mode) rx_prev_q <= 1'b1;
        else if (tq_tick)         rx_prev_q <= rx;
    end

    a_r4_sync_one_quantum: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_tick && seg_q == SEG_SYNC) |=> (seg_q == SEG_PH1));
    a_r5_ph1_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_q == SEG_PH1) |-> (qcnt_q < QCNT_W'((1 << TS1_W) + (1 << SJW_W))));
    a_r6_ph2_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_q == SEG_PH2) |-> (qcnt_q < QCNT_W'(1 << TS2_W)));
    a_r3_sample_in_ph1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt |=> (seg_q == SEG_PH2));
endmodule

// File: rtl/can_bt_sampler.sv
// Bit sampler: latches rx at the sample point, either as a single sample
// or as a majority over the last three quantum ticks.
module can_bt_sampler
    import can_bt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reset_mode,
    input  logic tq_tick,
    input  logic sample_pt,
    input  logic sam,
    input  logic rx,
    output logic rx_bit
);
    logic [1:0] hist_q;
    logic       vote;

    assign vote = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx) | (hist_q[0] & rx);

    // Keep the two previous quantum samples.
    always_ff @(posedge clk) begin
        if (!rst_n || reset_mode) hist_q <= 2'b11;
        else if (tq_tick)         hist_q <= {hist_q[0], rx};
    end

    // Update the sampled bit at the sample point.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_bit <= 1'b1;
        else if (sample_pt) rx_bit <= sam ? vote : rx;
    end

    a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_pt |=> $stable(rx_bit));
endmodule

// File: rtl/can_bit_timing.sv
// CAN bit timing generator top: configuration capture, quantum
// prescaler, segment sequencer and bit sampler.
module can_bit_timing
    import can_bt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bt_byte0,
    input  logic [7:0] bt_byte1,
    input  logic       reset_mode,
    input  logic       hard_sync_req,
    input  logic       rx,
    output logic       tq_tick,
    output logic       sample_strobe,
    output logic       rx_bit,
    output logic       bit_start
);
    timing_t timing;

    can_bt_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
        .byte0(bt_byte0), .byte1(bt_byte1), .timing(timing)
    );

    can_bt_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
        .brp(timing.brp), .tq_tick(tq_tick)
    );

    can_bt_seq u_seq (
        .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
        .tq_tick(tq_tick), .rx(rx), .hard_sync_req(hard_sync_req),
        .sjw(timing.sjw), .tseg1(timing.tseg1), .tseg2(timing.tseg2),
        .sample_pt(sample_strobe), .bit_start(bit_start)
    );

    can_bt_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
        .tq_tick(tq_tick), .sample_pt(sample_strobe), .sam(timing.sam),
        .rx(rx), .rx_bit(rx_bit)
    );

    a_r3_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe || bit_start) |-> tq_tick);
    a_r4_start_not_sample: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |-> !sample_strobe);
endmodule

// File: tb/can_bit_timing_test.sv
module can_bit_timing_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bt_byte0 = 8'hFF, bt_byte1 = 8'hFF;
    logic       reset_mode = 1'b0, hard_sync_req = 1'b0, rx = 1'b1;
    logic       tq_tick, sample_strobe, rx_bit, bit_start;
    int         cyc = 0, n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    can_bit_timing uut (
        .clk(clk), .rst_n(rst_n), .bt_byte0(bt_byte0), .bt_byte1(bt_byte1),
        .reset_mode(reset_mode), .hard_sync_req(hard_sync_req), .rx(rx),
        .tq_tick(tq_tick), .sample_strobe(sample_strobe), .rx_bit(rx_bit),
        .bit_start(bit_start)
    );

    // {byte0, byte1, tick period, bit clocks, sample offset in ticks}
    localparam logic [47:0] VEC [5] = '{
        {8'h00, 8'h37, 8'd2, 16'd26,  8'd8},
        {8'h01, 8'h14, 8'd4, 16'd32,  8'd5},
        {8'h43, 8'h70, 8'd8, 16'd80,  8'd1},
        {8'h02, 8'h0F, 8'd6, 16'd108, 8'd16},
        {8'hC0, 8'h92, 8'd2, 16'd12,  8'd3}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (tq_tick !== 1'b1);
    endtask

    task automatic wait_start(output int at);
        do @(negedge clk); while (bit_start !== 1'b1);
        at = cyc;
    endtask

    task automatic setup(input logic [7:0] b0, input logic [7:0] b1, input logic rxl);
        @(negedge clk);
        reset_mode = 1'b1;
        rx = rxl;
        bt_byte0 = b0;
        bt_byte1 = b1;
        repeat (4) @(negedge clk);
        reset_mode = 1'b0;
    endtask

    task automatic measure(output int gap, output int soff, output int bitc);
        int t0, ticks;
        bit fin;
        wait_start(t0);
        gap = 0; soff = -1; ticks = 0; fin = 1'b0;
        while (!fin) begin
            @(negedge clk);
            if (tq_tick === 1'b1) begin
                ticks++;
                if (gap == 0) gap = cyc - t0;
            end
            if (sample_strobe === 1'b1 && soff < 0) soff = ticks;
            if (bit_start === 1'b1) fin = 1'b1;
        end
        bitc = cyc - t0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int t0, t1, t2, gap, soff, bitc, seen;
        // R12: reset state
        repeat (5) @(negedge clk);
        check("R12 rx_bit after reset", rx_bit, 1);
        check("R12 no tick in reset", tq_tick, 0);
        rst_n = 1'b1;
        wait_start(t0);
        wait_start(t1);
        check("R12 cleared bytes give 6-clock bit", t1 - t0, 6);

        // R1 R2 R3 R4: table of configurations
        for (int i = 0; i < 5; i++) begin
            setup(VEC[i][47:40], VEC[i][39:32], 1'b1);
            measure(gap, soff, bitc);
            check("R1 tick period", gap, int'(VEC[i][31:24]));
            check("R2 bit length", bitc, int'(VEC[i][23:8]));
            check("R3 sample offset", soff, int'(VEC[i][7:0]));
        end

        // R10: writes outside reset mode are ignored
        setup(8'h00, 8'h37, 1'b1);
        bt_byte0 = 8'h05;
        bt_byte1 = 8'h7F;
        wait_start(t0);
        wait_start(t1);
        check("R10 bytes frozen", t1 - t0, 26);

        // R11: reset mode silences output, restart at sync
        @(negedge clk);
        reset_mode = 1'b1;
        seen = 0;
        repeat (40) begin
            @(negedge clk);
            if (tq_tick || sample_strobe || bit_start) seen++;
        end
        check("R11 quiet in reset mode", seen, 0);
        reset_mode = 1'b0;
        wait_tick();
        check("R11 first tick is bit start", bit_start, 1);
        t0 = cyc;
        wait_start(t1);
        check("R10 new bytes loaded in reset mode", t1 - t0, 300);

        // R5: edge in phase 1, jump width 2 then 4
        setup(8'h40, 8'h37, 1'b1);
        wait_start(t0);
        repeat (3) wait_tick();
        @(negedge clk); rx = 1'b0;
        wait_start(t1);
        check("R5 extend capped by jump width 2", t1 - t0, 30);
        setup(8'hC0, 8'h37, 1'b1);
        wait_start(t0);
        repeat (3) wait_tick();
        @(negedge clk); rx = 1'b0;
        wait_start(t1);
        check("R5 extend by phase error 4", t1 - t0, 34);

        // R6: edge in phase 2, jump width 1 then 4
        setup(8'h00, 8'h37, 1'b1);
        wait_start(t0);
        repeat (9) wait_tick();
        @(negedge clk); rx = 1'b0;
        wait_start(t1);
        check("R6 shorten capped by jump width 1", t1 - t0, 24);
        setup(8'hC0, 8'h37, 1'b1);
        wait_start(t0);
        repeat (9) wait_tick();
        @(negedge clk); rx = 1'b0;
        wait_start(t1);
        check("R6 shorten by remaining 2", t1 - t0, 22);

        // R7: edge on the sync tick changes nothing
        setup(8'h00, 8'h37, 1'b1);
        wait_start(t0);
        repeat (12) wait_tick();
        @(negedge clk); rx = 1'b0;
        wait_start(t1);
        wait_start(t2);
        check("R7 sync edge ignored", t2 - t1, 26);

        // R7: second edge in the same bit is ignored
        setup(8'h00, 8'h37, 1'b1);
        wait_start(t0);
        repeat (3) wait_tick();
        @(negedge clk); rx = 1'b0;
        repeat (7) wait_tick();
        @(negedge clk); rx = 1'b1;
        wait_tick();
        @(negedge clk); rx = 1'b0;
        wait_start(t1);
        check("R7 one correction per bit", t1 - t0, 28);

        // R8: hard sync restarts the bit
        setup(8'h00, 8'h37, 1'b1);
        hard_sync_req = 1'b1;
        wait_start(t0);
        repeat (3) wait_tick();
        @(negedge clk); rx = 1'b0;
        wait_start(t1);
        check("R8 hard sync restart", t1 - t0, 10);
        hard_sync_req = 1'b0;

        // R9: one-quantum glitch at the sample point, triple sampling
        setup(8'h00, 8'hB7, 1'b0);
        wait_start(t0);
        repeat (7) wait_tick();
        @(negedge clk); rx = 1'b1;
        wait_tick();
        check("R3 strobe at ninth tick", sample_strobe, 1);
        @(negedge clk);
        check("R9 majority rejects glitch", rx_bit, 0);
        rx = 1'b0;

        // R9: same glitch, single sample
        setup(8'h00, 8'h37, 1'b0);
        wait_start(t0);
        repeat (7) wait_tick();
        @(negedge clk); rx = 1'b1;
        wait_tick();
        check("R3 strobe at ninth tick single", sample_strobe, 1);
        @(negedge clk);
        check("R9 single sample takes glitch", rx_bit, 1);
        rx = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule